// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Block

This block is the host-facing register file of a two-channel serial communications controller. A processor reaches it over a byte bus with a 3-bit address, a write strobe and a read strobe. Each channel has one control port and one data port. Register access is indirect. A control write at pointer zero loads a register pointer, and it can also carry a command. The next control access then reaches the selected register, and after that the pointer falls back to zero.

Both channels share one interrupt request line. A nested scheme tracks which kind of interrupt, receive or transmit, is currently under service in each channel. A vector register reports the highest serviced source. A pending register shows every outstanding request. On the line side, each channel takes received bytes through a strobe and accept pair, takes a break indication, and presents transmitted bytes with a one-cycle strobe. Bit-level framing, baud generation and DMA belong to other blocks.

Top module: `dual_serial_regs`

## Requirements
- R1: Address bit 2 selects the channel (1 = channel A, 0 = channel B). Address bit 1 selects the control port (0) or the data port (1). Control port addresses are B=0 and A=4. Data port addresses are B=2 and A=6.
- R2: A control write while the pointer is 0 loads the pointer from data bits 2:0. When command bits 5:3 equal 1, the write adds 8 to the pointer. A control write at a non-zero pointer stores the register and returns the pointer to 0. A control read returns read register [pointer] (RR0, RR1, RR2 on channel B, RR3 on channel A, all others 0) and returns the pointer to 0.
- R3: After reset, RR0 reads 0x44, RR1 reads 0x06, the channel B RR2 vector reads 0x06 and channel A RR3 reads 0x00. The irq output is low, rx_rdy is low, and the break interrupt enable (WR15 bit 7) is set.
- R4: A write to WR9 with bits 7:6 = 01 resets channel B, 10 resets channel A, and 11 resets both channels and clears the status-high bit. With bits 7:6 = 00 the write stores bit 4 as the status-high bit. Resetting a single channel leaves the other channel and the status-high bit unchanged.
- R5: A data write stores the transmit byte. It drives tx_byte with a one-cycle tx_stb on the next cycle only when WR5 bit 3 is set. In both cases it sets RR0 bit 2 and RR1 bit 0 and raises the transmit interrupt.
- R6: rx_rdy is high exactly when WR3 bit 0 is set and RR0 bit 0 is clear. An accepted byte sets RR0 bit 0, is returned by a data read, and raises the receive interrupt. A data read clears RR0 bit 0 and the receive interrupt.
- R7: A channel requests an interrupt when WR1 bit 0 is set and at least one of these holds: WR1 bit 1 is set and a transmit interrupt is pending; WR1 bits 4:3 are 01 or 10 and a receive interrupt is pending; WR15 bit 7 and RR0 bit 7 are both set. irq is the OR of the two channels.
- R8: Channel A RR3 shows the pending interrupts: A receive 0x20, A transmit 0x10, B receive 0x04, B transmit 0x02.
- R9: The channel B RR2 vector reports the serviced source in priority order A receive, A transmit, B receive, B transmit. With status-high 0 the values are 0x0C, 0x08, 0x04, 0x00. With status-high 1 they are 0x30, 0x10, 0x20, 0x00. With nothing under service the vector is 0x06, or 0x60 with status-high 1.
- R10: A new receive or transmit interrupt enters service only if the other kind of the same channel is not in service. Clearing one kind puts the other kind into service if it is still pending.
- R11: Command 5 (bits 5:3) clears the transmit interrupt. Command 7 clears the interrupt in service, receive before transmit.
- R12: The break input sets RR0 bit 7. The bit stays set until that channel is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address (bit 2 channel, bit 1 control/data) |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Combined interrupt request |
| rx_byte | input | 2x8 | Received byte per channel (index 1 = A) |
| rx_stb | input | 2 | Received byte strobe per channel |
| rx_rdy | output | 2 | Channel can accept a byte |
| brk | input | 2 | Break indication per channel |
| tx_byte | output | 2x8 | Transmitted byte per channel |
| tx_stb | output | 2 | One-cycle transmit strobe per channel |

## Verification
Some properties are checked by the assertions on every cycle. The pointer returns to zero after any access at a non-zero pointer and after any control read. An accepted byte always sets the character-available bit. The break flag stays set until a reset. tx_stb appears only after a data write. A channel never has receive and transmit in service at the same time, and a source in service is always pending. Other behaviour only the directed scenarios can show: the exact vector values under both status-high settings, the handover of service when one kind is cleared, the selectivity of the per-channel resets, and the register values returned through the indirect pointer.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
    // Shared constants and interrupt-state helpers for the serial register block.
    localparam int PTR_W = 4;

    localparam logic [7:0] RR0_RST  = 8'h44;
    localparam logic [7:0] RR1_RST  = 8'h06;
    localparam logic [2:0] CMD_HIGH = 3'd1;
    localparam logic [2:0] CMD_CLRTX = 3'd5;
    localparam logic [2:0] CMD_CLRSV = 3'd7;
    localparam logic [PTR_W-1:0] PTR_RESETS = 4'd9;

    typedef struct packed {
        logic rx_pend;
        logic tx_pend;
        logic rx_svc;
        logic tx_svc;
    } int_flags_t;

    // Receive interrupt is cleared; a pending transmit then takes service.
    function automatic int_flags_t f_clr_rx(int_flags_t f);
        int_flags_t r = f;
        r.rx_pend = 1'b0;
        r.rx_svc  = 1'b0;
        if (r.tx_pend) r.tx_svc = 1'b1;
        return r;
    endfunction

    // Transmit interrupt is cleared; a pending receive then takes service.
    function automatic int_flags_t f_clr_tx(int_flags_t f);
        int_flags_t r = f;
        r.tx_pend = 1'b0;
        r.tx_svc  = 1'b0;
        if (r.rx_pend) r.rx_svc = 1'b1;
        return r;
    endfunction

    // Transmit interrupt raised; enters service unless receive is serviced.
    function automatic int_flags_t f_set_tx(int_flags_t f);
        int_flags_t r = f;
        r.tx_pend = 1'b1;
        if (!r.rx_svc) r.tx_svc = 1'b1;
        return r;
    endfunction

    // Receive interrupt raised; enters service unless transmit is serviced.
    function automatic int_flags_t f_set_rx(int_flags_t f);
        int_flags_t r = f;
        r.rx_pend = 1'b1;
        if (!r.tx_svc) r.rx_svc = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/ser_chan.sv
// One channel's register bank: the indirect pointer, the stored write-register
// fields that drive behaviour, RR0/RR1, and the receive and transmit byte paths.
// Assumes at most one bus access per cycle and that chan_rst has priority.
module ser_chan
    import serreg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_rst,
    input  logic             ctl_wr,
    input  logic             ctl_rd,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    rx_byte,
    input  logic             rx_stb,
    input  logic             brk,
    output logic             rx_rdy,
    output logic             rx_acc,
    output logic [DW-1:0]    tx_byte,
    output logic             tx_stb,
    output logic [PTR_W-1:0] ptr,
    output logic [DW-1:0]    rx_hold,
    output logic [DW-1:0]    rr0,
    output logic [DW-1:0]    rr1,
    output logic             ie_master,
    output logic             ie_tx,
    output logic [1:0]       ie_rx_mode,
    output logic             ie_break,
    output logic             wr9_we,
    output logic             cmd_clr_tx,
    output logic             cmd_clr_svc
);
    logic       rx_en;
    logic       tx_en;
    logic [2:0] cmd;
    logic       at_zero;

    assign cmd         = wdata[5:3];
    assign at_zero     = (ptr == '0);
    assign rx_rdy      = rx_en & ~rr0[0];
    assign rx_acc      = rx_stb & rx_rdy;
    assign cmd_clr_tx  = ctl_wr & at_zero & (cmd == CMD_CLRTX);
    assign cmd_clr_svc = ctl_wr & at_zero & (cmd == CMD_CLRSV);
    assign wr9_we      = ctl_wr & (ptr == PTR_RESETS);

    // Pointer: loaded at zero, returns to zero after any other control access.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst)  ptr <= '0;
        else if (ctl_wr)         ptr <= at_zero ? {cmd == CMD_HIGH, wdata[2:0]} : '0;
        else if (ctl_rd)         ptr <= '0;
    end

    // Write-register fields that the block's behaviour depends on.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            ie_master  <= 1'b0;
            ie_tx      <= 1'b0;
            ie_rx_mode <= 2'b00;
            rx_en      <= 1'b0;
            tx_en      <= 1'b0;
            ie_break   <= 1'b1;
        end else if (ctl_wr) begin
            case (ptr)
                4'd1: begin
                    ie_master  <= wdata[0];
                    ie_tx      <= wdata[1];
                    ie_rx_mode <= wdata[4:3];
                end
                4'd3:    rx_en    <= wdata[0];
                4'd5:    tx_en    <= wdata[3];
                4'd15:   ie_break <= wdata[7];
                default: ;
            endcase
        end
    end

    // Status registers: character available, transmit empty, all sent, break.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            rr0 <= RR0_RST;
            rr1 <= RR1_RST;
        end else begin
            if (dat_rd) rr0[0] <= 1'b0;
            if (rx_acc) rr0[0] <= 1'b1;
            if (dat_wr) begin
                rr0[2] <= 1'b1;
                rr1[0] <= 1'b1;
            end
            if (brk) rr0[7] <= 1'b1;
        end
    end

    // Byte paths: capture received byte, present transmitted byte with strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            rx_hold <= '0;
            tx_byte <= '0;
            tx_stb  <= 1'b0;
        end else begin
            if (rx_acc) rx_hold <= rx_byte;
            if (dat_wr) tx_byte <= wdata;
            tx_stb <= dat_wr & tx_en;
        end
    end

    // R2
    // ptr_return_chk: a non-zero pointer access or a control read leaves pointer 0
    ptr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_wr && !at_zero) || ctl_rd) |=> (ptr == '0));
    // R6
    rx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_acc && !chan_rst) |=> rr0[0]);
    // R12
    break_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rr0[7] && !chan_rst) |=> rr0[7]);
    // R5
    tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> $past(dat_wr));
endmodule

// File: rtl/irq_ctrl.sv
// Nested interrupt state for all channels: per-channel pending and
// under-service flags, the shared vector (RR2), the pending register (RR3)
// and the combined request. Channel index 1 is A, index 0 is B.
module irq_ctrl
    import serreg_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   chan_rst,
    input  logic [NCH-1:0]   set_rx,
    input  logic [NCH-1:0]   clr_rx,
    input  logic [NCH-1:0]   set_tx,
    input  logic [NCH-1:0]   clr_tx,
    input  logic [NCH-1:0]   clr_svc,
    input  logic [NCH-1:0]   ie_master,
    input  logic [NCH-1:0]   ie_tx,
    input  logic [NCH-1:0][1:0] ie_rx_mode,
    input  logic [NCH-1:0]   ie_break,
    input  logic [NCH-1:0]   brk_flag,
    input  logic             stat_hi,
    output logic [DW-1:0]    vector,
    output logic [DW-1:0]    pending,
    output logic             irq
);
    int_flags_t [NCH-1:0] cur;
    int_flags_t [NCH-1:0] nxt;
    logic       [NCH-1:0] ch_req;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Apply this cycle's clear and raise events in a fixed order.
        always_comb begin
            nxt[i] = cur[i];
            if (clr_rx[i]) nxt[i] = f_clr_rx(nxt[i]);
            if (clr_tx[i]) nxt[i] = f_clr_tx(nxt[i]);
            if (clr_svc[i]) begin
                if (nxt[i].rx_svc)      nxt[i] = f_clr_rx(nxt[i]);
                else if (nxt[i].tx_svc) nxt[i] = f_clr_tx(nxt[i]);
            end
            if (set_tx[i]) nxt[i] = f_set_tx(nxt[i]);
            if (set_rx[i]) nxt[i] = f_set_rx(nxt[i]);
        end

        // Hold the flags; a channel reset empties them.
        always_ff @(posedge clk) begin
            if (!rst_n || chan_rst[i]) cur[i] <= '0;
            else                       cur[i] <= nxt[i];
        end

        // Per-channel request from enables and pending sources.
        always_comb begin
            ch_req[i] = ie_master[i] &
                        ((ie_tx[i] & cur[i].tx_pend) |
                         (((ie_rx_mode[i] == 2'b01) || (ie_rx_mode[i] == 2'b10)) & cur[i].rx_pend) |
                         (ie_break[i] & brk_flag[i]));
        end

        // R10
        // single_service_chk: receive and transmit never both in service
        single_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(cur[i].rx_svc && cur[i].tx_svc));
        // R10
        svc_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cur[i].rx_svc |-> cur[i].rx_pend) and (cur[i].tx_svc |-> cur[i].tx_pend));
        // R11
        clr_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_tx[i] && !set_tx[i]) |=> !cur[i].tx_pend);
    end

    assign irq = |ch_req;

    // Pending register layout: A rx 0x20, A tx 0x10, B rx 0x04, B tx 0x02.
    always_comb begin
        pending    = '0;
        pending[5] = cur[1].rx_pend;
        pending[4] = cur[1].tx_pend;
        pending[2] = cur[0].rx_pend;
        pending[1] = cur[0].tx_pend;
    end

    // Vector: highest serviced source, value modified by status-high.
    always_comb begin
        if (cur[1].rx_svc)      vector = stat_hi ? 8'h30 : 8'h0C;
        else if (cur[1].tx_svc) vector = stat_hi ? 8'h10 : 8'h08;
        else if (cur[0].rx_svc) vector = stat_hi ? 8'h20 : 8'h04;
        else if (cur[0].tx_svc) vector = 8'h00;
        else                    vector = stat_hi ? 8'h60 : 8'h06;
    end
endmodule

// File: rtl/dual_serial_regs.sv
// Top of the two-channel serial register block: decodes the byte bus,
// instantiates one bank per channel, handles the shared WR9 (resets and
// status-high) and muxes read data. Assumes bus_wr and bus_rd are never
// high together and each access lasts one cycle.
module dual_serial_regs
    import serreg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    input  logic [1:0][DW-1:0] rx_byte,
    input  logic [1:0]        rx_stb,
    output logic [1:0]        rx_rdy,
    input  logic [1:0]        brk,
    output logic [1:0][DW-1:0] tx_byte,
    output logic [1:0]        tx_stb
);
    localparam int NCH = 2;

    logic [NCH-1:0]            sel, ctl_wr, ctl_rd, dat_wr, dat_rd, rx_acc;
    logic [NCH-1:0]            chan_rst, wr9_we, clr_tx, clr_svc;
    logic [NCH-1:0]            ie_master, ie_tx, ie_break, brk_flag;
    logic [NCH-1:0][1:0]       ie_rx_mode;
    logic [NCH-1:0][PTR_W-1:0] ptr;
    logic [NCH-1:0][DW-1:0]    rx_hold, rr0, rr1;
    logic [DW-1:0]             vector, pending;
    logic                      stat_hi, wr9_hit;
    logic                      c;

    assign sel = bus_addr[2] ? 2'b10 : 2'b01;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign ctl_wr[i]   = bus_wr & sel[i] & ~bus_addr[1];
        assign ctl_rd[i]   = bus_rd & sel[i] & ~bus_addr[1];
        assign dat_wr[i]   = bus_wr & sel[i] &  bus_addr[1];
        assign dat_rd[i]   = bus_rd & sel[i] &  bus_addr[1];
        assign brk_flag[i] = rr0[i][7];

        ser_chan #(.DW(DW)) u_chan (
            .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst[i]),
            .ctl_wr(ctl_wr[i]), .ctl_rd(ctl_rd[i]),
            .dat_wr(dat_wr[i]), .dat_rd(dat_rd[i]),
            .wdata(bus_wdata), .rx_byte(rx_byte[i]), .rx_stb(rx_stb[i]),
            .brk(brk[i]), .rx_rdy(rx_rdy[i]), .rx_acc(rx_acc[i]),
            .tx_byte(tx_byte[i]), .tx_stb(tx_stb[i]), .ptr(ptr[i]),
            .rx_hold(rx_hold[i]), .rr0(rr0[i]), .rr1(rr1[i]),
            .ie_master(ie_master[i]), .ie_tx(ie_tx[i]),
            .ie_rx_mode(ie_rx_mode[i]), .ie_break(ie_break[i]),
            .wr9_we(wr9_we[i]), .cmd_clr_tx(clr_tx[i]), .cmd_clr_svc(clr_svc[i])
        );
    end

    // WR9 is shared: bit 6 resets B, bit 7 resets A.
    assign wr9_hit  = |wr9_we;
    assign chan_rst = wr9_hit ? {bus_wdata[7], bus_wdata[6]} : 2'b00;

    // Status-high bit: stored by a plain WR9 write, cleared by a full reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   stat_hi <= 1'b0;
        else if (wr9_hit && bus_wdata[7:6] == 2'b11)  stat_hi <= 1'b0;
        else if (wr9_hit && bus_wdata[7:6] == 2'b00)  stat_hi <= bus_wdata[4];
    end

    irq_ctrl #(.NCH(NCH), .DW(DW)) u_irq (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
        .set_rx(rx_acc), .clr_rx(dat_rd), .set_tx(dat_wr),
        .clr_tx(clr_tx), .clr_svc(clr_svc),
        .ie_master(ie_master), .ie_tx(ie_tx), .ie_rx_mode(ie_rx_mode),
        .ie_break(ie_break), .brk_flag(brk_flag), .stat_hi(stat_hi),
        .vector(vector), .pending(pending), .irq(irq)
    );

    // Read mux: data port returns the received byte, control port RR[ptr].
    assign c = bus_addr[2];
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr[1]) bus_rdata = rx_hold[c];
            else begin
                case (ptr[c])
                    4'd0:    bus_rdata = rr0[c];
                    4'd1:    bus_rdata = rr1[c];
                    4'd2:    bus_rdata = c ? '0 : vector;
                    4'd3:    bus_rdata = c ? pending : '0;
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    // R8
    // rx_pending_chk: an accepted byte shows up in the pending register
    rx_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_acc[1] && !chan_rst[1]) |=> pending[5]);
    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_master[0] && !ie_master[1]) |-> !irq);
endmodule

// File: tb/dual_serial_regs_test.sv
module dual_serial_regs_test;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      bus_addr = '0;
    logic [7:0]      bus_wdata = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [7:0]      bus_rdata;
    logic            irq;
    logic [1:0][7:0] rx_byte = '0;
    logic [1:0]      rx_stb = '0;
    logic [1:0]      rx_rdy;
    logic [1:0]      brk = '0;
    logic [1:0][7:0] tx_byte;
    logic [1:0]      tx_stb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [2:0] CTL_B = 3'd0, DAT_B = 3'd2, CTL_A = 3'd4, DAT_A = 3'd6;

    always #2.5 clk = ~clk;

    dual_serial_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
        .rx_byte(rx_byte), .rx_stb(rx_stb), .rx_rdy(rx_rdy), .brk(brk),
        .tx_byte(tx_byte), .tx_stb(tx_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Read register n of the channel whose control port is ctl.
    task automatic rreg(input logic [2:0] ctl, input logic [3:0] n, output logic [7:0] d);
        if (n != 0) bwr(ctl, {2'b00, n[3], n[2:0]});
        brd(ctl, d);
    endtask

    task automatic wreg(input logic [2:0] ctl, input logic [3:0] n, input logic [7:0] v);
        bwr(ctl, {2'b00, n[3], n[2:0]});
        bwr(ctl, v);
    endtask

    task automatic rx_put(input int ch, input logic [7:0] b);
        @(negedge clk);
        rx_byte[ch] = b; rx_stb[ch] = 1'b1;
        @(negedge clk);
        rx_stb[ch] = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        chk("R3 irq", irq, 0);
        chk("R3 rx_rdy", rx_rdy, 0);
        rreg(CTL_A, 0, d); chk("R3 RR0 A", d, 8'h44);
        rreg(CTL_A, 1, d); chk("R3 RR1 A", d, 8'h06);
        rreg(CTL_B, 2, d); chk("R3 RR2 B vector", d, 8'h06);
        rreg(CTL_A, 3, d); chk("R3 RR3 A", d, 8'h00);
    endtask

    task automatic t_pointer();
        logic [7:0] d;
        rreg(CTL_A, 2, d); chk("R2 RR2 on A reads 0", d, 8'h00);
        brd(CTL_A, d);     chk("R2 pointer back to 0 after read", d, 8'h44);
        bwr(CTL_B, 8'h0B); // command 1 + pointer 3 -> register 11
        brd(CTL_B, d);     chk("R2 high bank read of RR11", d, 8'h00);
        brd(CTL_B, d);     chk("R2 pointer back to 0 after high read", d, 8'h44);
        bwr(CTL_A, 8'h03);
        brd(CTL_B, d);     chk("R1 channel B pointer independent of A", d, 8'h44);
        brd(CTL_A, d);     chk("R1 channel A RR3 via own pointer", d, 8'h00);
    endtask

    task automatic t_transmit();
        logic [7:0] d;
        bwr(DAT_A, 8'h5A);
        chk("R5 no tx_stb with WR5 bit3 clear", tx_stb, 2'b00);
        rreg(CTL_A, 3, d); chk("R8 A tx pending 0x10", d, 8'h10);
        rreg(CTL_A, 1, d); chk("R5 RR1 all-sent set", d, 8'h07);
        chk("R7 no irq with WR1 clear", irq, 0);
        wreg(CTL_A, 1, 8'h03);
        chk("R7 irq from A transmit", irq, 1);
        rreg(CTL_B, 2, d); chk("R9 vector A tx", d, 8'h08);
        bwr(CTL_A, 8'h28);
        rreg(CTL_A, 3, d); chk("R11 command 5 clears tx pending", d, 8'h00);
        chk("R11 irq low after command 5", irq, 0);
        rreg(CTL_B, 2, d); chk("R9 idle vector", d, 8'h06);
        wreg(CTL_A, 5, 8'h08);
        bwr(DAT_A, 8'hA5);
        chk("R5 tx_stb with WR5 bit3 set", tx_stb, 2'b10);
        chk("R5 tx_byte", tx_byte[1], 8'hA5);
        @(negedge clk);
        chk("R5 tx_stb lasts one cycle", tx_stb, 2'b00);
        bwr(CTL_A, 8'h28);
    endtask

    task automatic t_receive();
        logic [7:0] d;
        chk("R6 rx_rdy low with WR3 bit0 clear", rx_rdy[0], 0);
        wreg(CTL_B, 3, 8'h01);
        wreg(CTL_B, 1, 8'h11);
        chk("R6 rx_rdy high when enabled", rx_rdy[0], 1);
        rx_put(0, 8'h3C);
        chk("R6 rx_rdy low with char held", rx_rdy[0], 0);
        rreg(CTL_B, 0, d); chk("R6 RR0 B char available", d, 8'h45);
        rreg(CTL_A, 3, d); chk("R8 B rx pending 0x04", d, 8'h04);
        rreg(CTL_B, 2, d); chk("R9 vector B rx", d, 8'h04);
        chk("R7 irq from B receive", irq, 1);
        rx_put(0, 8'hEE);
        brd(DAT_B, d);     chk("R6 data read returns first byte", d, 8'h3C);
        chk("R6 irq low after data read", irq, 0);
        chk("R6 rx_rdy back high", rx_rdy[0], 1);
        rreg(CTL_A, 3, d); chk("R6 receive pending cleared", d, 8'h00);
    endtask

    task automatic t_nesting();
        logic [7:0] d;
        wreg(CTL_A, 3, 8'h01);
        bwr(DAT_A, 8'h11);
        rreg(CTL_B, 2, d); chk("R10 tx takes service", d, 8'h08);
        rx_put(1, 8'h77);
        rreg(CTL_A, 3, d); chk("R8 A rx and tx pending", d, 8'h30);
        rreg(CTL_B, 2, d); chk("R10 rx waits while tx serviced", d, 8'h08);
        bwr(CTL_A, 8'h38);
        rreg(CTL_B, 2, d); chk("R10 rx enters service after tx cleared", d, 8'h0C);
        rreg(CTL_A, 3, d); chk("R11 command 7 cleared tx", d, 8'h20);
        wreg(CTL_A, 9, 8'h10);
        rreg(CTL_B, 2, d); chk("R9 status-high A rx vector", d, 8'h30);
        bwr(CTL_A, 8'h38);
        rreg(CTL_B, 2, d); chk("R9 status-high idle vector", d, 8'h60);
        rreg(CTL_A, 3, d); chk("R11 command 7 cleared rx", d, 8'h00);
        rreg(CTL_A, 0, d); chk("R11 char still available", d, 8'h45);
    endtask

    task automatic t_break_resets();
        logic [7:0] d;
        @(negedge clk); brk[0] = 1'b1;
        @(negedge clk); brk[0] = 1'b0;
        repeat (3) @(negedge clk);
        rreg(CTL_B, 0, d); chk("R12 break bit sticky", d, 8'hC4);
        chk("R7 irq from break", irq, 1);
        wreg(CTL_B, 9, 8'h40);
        rreg(CTL_B, 0, d); chk("R4 channel B reset RR0", d, 8'h44);
        chk("R4 irq low after B reset", irq, 0);
        chk("R4 B rx disabled after reset", rx_rdy[0], 0);
        rreg(CTL_A, 0, d); chk("R4 channel A kept on B reset", d, 8'h45);
        rreg(CTL_B, 2, d); chk("R4 status-high kept on B reset", d, 8'h60);
        wreg(CTL_A, 9, 8'h80);
        rreg(CTL_A, 0, d); chk("R4 channel A reset RR0", d, 8'h44);
        wreg(CTL_B, 9, 8'hC0);
        rreg(CTL_B, 2, d); chk("R4 full reset clears status-high", d, 8'h06);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_pointer();
        t_transmit();
        t_receive();
        t_nesting();
        t_break_resets();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule